// File: doc/BRIEF.md
# TDM Sense-Data Slot Transmitter

This block puts one device's measurement words onto a shared time-division-multiplexed serial bus. It is clocked by the bus bit clock. It watches a frame sync pulse that is one bit wide and counts bits and 16-bit slots from that pulse. It drives the serial line only during the group of four consecutive slots picked by a 2-bit group select. The words it sends are a 16-bit output-voltage sample, a 16-bit output-current sample and an 8-bit supply-rail sample. Each word arrives in parallel with its own valid strobe. The output is a data bit plus an output enable that together form a tri-statable pin. Several such transmitters, each set to a different group, can share one data wire.

Strobed samples go into holding registers. They are copied into the frame registers only when a sync arrives, so every frame carries a consistent set of words. If the sync goes missing, the block keeps counting in 256-bit frames. After 512 bit clocks with no sync it goes quiet until a new sync arrives.

Frame tracker states:
- WAIT: no sync has been seen, or the sync has been lost.
- LOCKED: fewer than 256 bits since the last sync.
- COAST: between 256 and 511 bits since the last sync.

Transitions:
- SYNC_SEEN: any state goes to LOCKED with the bit count at zero when the sync is sampled high.
- FRAME_OVER: LOCKED goes to COAST after bit 255.
- SYNC_LOST: COAST goes to WAIT after bit 511.

Top module: `tdm_sense_tx`

## Requirements
- R1: While `rst_n` is low, and after reset until a sync is seen, `tx_oe` is 0 and `tx_dat` is 0.
- R2: Data goes out MSB first and changes on the falling edge of `clk`. Bit k of a frame (k = 0 is the MSB of slot 1) is valid at the (k+1)-th rising edge after the rising edge at which `fsync` is sampled high.
- R3: Group select value g (0..3), sampled at the sync edge, makes the block own slots 4g+1 to 4g+4. These are frame bits 64g to 64g+63.
- R4: Within the owned group, slot offset 0 carries the voltage word and offset 1 carries the current word. Offset 2 carries the supply byte in bits 15..8, with bits 7..0 zero.
- R5: Slot offset 3 of the owned group, and every slot outside the group, has `tx_oe` = 0 and `tx_dat` = 0.
- R6: A valid strobe loads its holding register. The frame words are copied from the holding registers at the sync edge. A strobe at the same edge as the sync, or later in the frame, shows up in the next frame. Holding registers reset to zero.
- R7: A sync at any bit position restarts the count at slot 1. Frames of 4, 8, 12 and 16 slots are all served.
- R8: With no further sync, counting continues and wraps every 256 bits, so the owned slots repeat from bit 256 on.
- R9: When 512 bit clocks pass after a sync without another sync, `tx_oe` stays 0 until the next sync, which restores normal output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync | input | 1 | Frame sync pulse, one bit clock wide |
| grp_sel | input | 2 | Slot group select |
| volt_data | input | 16 | Voltage sample |
| volt_vld | input | 1 | Voltage sample strobe |
| curr_data | input | 16 | Current sample |
| curr_vld | input | 1 | Current sample strobe |
| sup_data | input | 8 | Supply sample |
| sup_vld | input | 1 | Supply sample strobe |
| tx_dat | output | 1 | Serial data bit |
| tx_oe | output | 1 | Output enable; 0 means the line is released |

## Verification
The hardest situations to reach from the ports are the coasting window and the loss of sync. Both need a sync followed by more than 256 and then more than 512 silent bit clocks. The stimulus produces them with one long run that has no sync, and then a fresh sync to show recovery. The bench also lines up sample strobes with the sync edge itself and with bits in the middle of a frame, to show which frame picks each value up. The group and frame-length sweep covers all sixteen combinations, including groups that a short frame never reaches.

// File: rtl/tdm_sense_pkg.sv
package tdm_sense_pkg;
    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,
        ST_LOCKED = 2'd1,
        ST_COAST  = 2'd2
    } trk_state_e;
endpackage

// File: rtl/tdm_frame_tracker.sv
module tdm_frame_tracker
    import tdm_sense_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int TIMEOUT    = 512,
    localparam int CNT_W     = $clog2(TIMEOUT),
    localparam int POS_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    output trk_state_e       st,
    output logic [POS_W-1:0] frame_pos
);
    trk_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_WAIT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_WAIT: begin
                cnt_d = '0;
                if (fsync) st_d = ST_LOCKED;
            end
            ST_LOCKED: begin
                if (fsync) begin
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(FRAME_BITS - 1)) st_d = ST_COAST;
                end
            end
            ST_COAST: begin
                if (fsync) begin
                    st_d  = ST_LOCKED;
                    cnt_d = '0;
                end else if (cnt_q == CNT_W'(TIMEOUT - 1)) begin
                    st_d  = ST_WAIT;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                st_d  = ST_WAIT;
                cnt_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        st        = st_q;
        frame_pos = cnt_q[POS_W-1:0];
    end

    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (st_q == ST_LOCKED && cnt_q == '0)); // R7
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_WAIT && !fsync && cnt_q != CNT_W'(TIMEOUT - 1))
        |=> cnt_q == $past(cnt_q) + 1'b1); // R8
    AST_TIMEOUT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COAST && !fsync && cnt_q == CNT_W'(TIMEOUT - 1))
        |=> st_q == ST_WAIT); // R9
endmodule

// File: rtl/tdm_word_bank.sv
module tdm_word_bank #(
    parameter int SLOT_W = 16,
    parameter int SUP_W  = 8,
    parameter int GRP_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic [GRP_W-1:0]  grp_in,
    input  logic [SLOT_W-1:0] v_in,
    input  logic              v_vld,
    input  logic [SLOT_W-1:0] i_in,
    input  logic              i_vld,
    input  logic [SUP_W-1:0]  s_in,
    input  logic              s_vld,
    output logic [SLOT_W-1:0] v_word,
    output logic [SLOT_W-1:0] i_word,
    output logic [SLOT_W-1:0] s_word,
    output logic [GRP_W-1:0]  grp_q
);
    logic [SLOT_W-1:0] v_hold, i_hold, v_frm, i_frm;
    logic [SUP_W-1:0]  s_hold, s_frm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_hold <= '0;
            i_hold <= '0;
            s_hold <= '0;
        end else begin
            if (v_vld) v_hold <= v_in;
            if (i_vld) i_hold <= i_in;
            if (s_vld) s_hold <= s_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_frm <= '0;
            i_frm <= '0;
            s_frm <= '0;
            grp_q <= '0;
        end else if (frame_sync) begin
            v_frm <= v_hold;
            i_frm <= i_hold;
            s_frm <= s_hold;
            grp_q <= grp_in;
        end
    end

    assign v_word = v_frm;
    assign i_word = i_frm;

    generate
        if (SUP_W < SLOT_W) begin : g_pad
            assign s_word = {s_frm, {(SLOT_W - SUP_W){1'b0}}};
        end else begin : g_trim
            assign s_word = s_frm[SUP_W-1 -: SLOT_W];
        end
    endgenerate

    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_sync |=> ($stable(v_frm) && $stable(i_frm) && $stable(s_frm))); // R6
endmodule

// File: rtl/tdm_slot_driver.sv
module tdm_slot_driver
    import tdm_sense_pkg::*;
#(
    parameter int SLOT_W    = 16,
    parameter int SLOTS_MAX = 16,
    localparam int BIT_LOG  = $clog2(SLOT_W),
    localparam int SLOT_LOG = $clog2(SLOTS_MAX),
    localparam int POS_W    = BIT_LOG + SLOT_LOG,
    localparam int GRP_W    = SLOT_LOG - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  trk_state_e        st,
    input  logic [POS_W-1:0]  frame_pos,
    input  logic [GRP_W-1:0]  grp_q,
    input  logic [SLOT_W-1:0] v_word,
    input  logic [SLOT_W-1:0] i_word,
    input  logic [SLOT_W-1:0] s_word,
    output logic              tx_dat,
    output logic              tx_oe
);
    logic [SLOT_LOG-1:0] slot;
    logic [1:0]          slot_ofs;
    logic [BIT_LOG-1:0]  bit_idx, sel;
    logic                drv_en, drv_bit;

    assign slot     = frame_pos[BIT_LOG +: SLOT_LOG];
    assign slot_ofs = slot[1:0];
    assign bit_idx  = frame_pos[BIT_LOG-1:0];
    assign sel      = BIT_LOG'(SLOT_W - 1) - bit_idx;

    always_comb begin
        drv_en  = 1'b0;
        drv_bit = 1'b0;
        if (st != ST_WAIT && slot[SLOT_LOG-1:2] == grp_q) begin
            unique case (slot_ofs)
                2'd0: begin drv_en = 1'b1; drv_bit = v_word[sel]; end
                2'd1: begin drv_en = 1'b1; drv_bit = i_word[sel]; end
                2'd2: begin drv_en = 1'b1; drv_bit = s_word[sel]; end
                default: begin drv_en = 1'b0; drv_bit = 1'b0; end
            endcase
        end
    end

    // output register, launched on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_oe  <= 1'b0;
            tx_dat <= 1'b0;
        end else begin
            tx_oe  <= drv_en;
            tx_dat <= drv_bit;
        end
    end

    AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |-> !tx_oe); // R9
    AST_SLOT4_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_ofs == 2'd3) |-> (!tx_oe && !tx_dat)); // R5
    AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (slot[SLOT_LOG-1:2] != grp_q) |-> !tx_oe); // R3
endmodule

// File: rtl/tdm_sense_tx.sv
module tdm_sense_tx
    import tdm_sense_pkg::*;
#(
    parameter int SLOT_W     = 16,
    parameter int SLOTS_MAX  = 16,
    parameter int SUP_W      = 8,
    parameter int TIMEOUT    = 512,
    localparam int GRP_W     = $clog2(SLOTS_MAX) - 2,
    localparam int FRAME_BITS = SLOT_W * SLOTS_MAX,
    localparam int POS_W     = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic [GRP_W-1:0]  grp_sel,
    input  logic [SLOT_W-1:0] volt_data,
    input  logic              volt_vld,
    input  logic [SLOT_W-1:0] curr_data,
    input  logic              curr_vld,
    input  logic [SUP_W-1:0]  sup_data,
    input  logic              sup_vld,
    output logic              tx_dat,
    output logic              tx_oe
);
    trk_state_e        st;
    logic [POS_W-1:0]  frame_pos;
    logic [GRP_W-1:0]  grp_q;
    logic [SLOT_W-1:0] v_word, i_word, s_word;

    tdm_frame_tracker #(.FRAME_BITS(FRAME_BITS), .TIMEOUT(TIMEOUT)) u_trk (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .st(st), .frame_pos(frame_pos)
    );

    tdm_word_bank #(.SLOT_W(SLOT_W), .SUP_W(SUP_W), .GRP_W(GRP_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .frame_sync(fsync), .grp_in(grp_sel),
        .v_in(volt_data), .v_vld(volt_vld), .i_in(curr_data), .i_vld(curr_vld),
        .s_in(sup_data), .s_vld(sup_vld),
        .v_word(v_word), .i_word(i_word), .s_word(s_word), .grp_q(grp_q)
    );

    tdm_slot_driver #(.SLOT_W(SLOT_W), .SLOTS_MAX(SLOTS_MAX)) u_drv (
        .clk(clk), .rst_n(rst_n), .st(st), .frame_pos(frame_pos), .grp_q(grp_q),
        .v_word(v_word), .i_word(i_word), .s_word(s_word),
        .tx_dat(tx_dat), .tx_oe(tx_oe)
    );
endmodule

// File: tb/tb_tdm_sense_tx.sv
module tb_tdm_sense_tx;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0, fsync = 1'b0;
    logic [1:0]  grp_sel = 2'd0;
    logic [15:0] volt_data = '0, curr_data = '0;
    logic [7:0]  sup_data = '0;
    logic        volt_vld = 1'b0, curr_vld = 1'b0, sup_vld = 1'b0;
    logic        tx_dat, tx_oe;

    tdm_sense_tx dut (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .grp_sel(grp_sel),
        .volt_data(volt_data), .volt_vld(volt_vld),
        .curr_data(curr_data), .curr_vld(curr_vld),
        .sup_data(sup_data), .sup_vld(sup_vld),
        .tx_dat(tx_dat), .tx_oe(tx_oe)
    );

    int total = 0, bad = 0;

    // reference model built from the requirements
    bit          m_act = 1'b0;
    int          m_pos = 0, m_grp = 0;
    logic [15:0] h_v = '0, h_i = '0, f_v = '0, f_i = '0;
    logic [7:0]  h_s = '0, f_s = '0;

    task automatic tick(input string req);
        logic  e_oe, e_dat;
        int    slot, ofs, b;
        logic [15:0] w;
        string auto_tag;
        @(posedge clk);
        #2;
        slot = (m_pos / 16) % 16;
        ofs  = slot % 4;
        b    = 15 - (m_pos % 16);
        e_oe = 1'b0; e_dat = 1'b0;
        if (!m_act) auto_tag = "R9";
        else if (slot / 4 != m_grp || ofs == 3) auto_tag = "R5";
        else begin
            auto_tag = "R4";
            w = (ofs == 0) ? f_v : (ofs == 1) ? f_i : {f_s, 8'h00};
            e_oe = 1'b1; e_dat = w[b];
        end
        total++;
        if (tx_oe !== e_oe || tx_dat !== e_dat) begin
            bad++;
            $display("FAIL %s/%s pos=%0d actual oe=%b dat=%b expected oe=%b dat=%b",
                     req, auto_tag, m_pos, tx_oe, tx_dat, e_oe, e_dat);
        end
        // advance the model with the inputs seen at this edge
        if (!rst_n) begin
            m_act = 0; m_pos = 0; m_grp = 0;
            h_v = '0; h_i = '0; h_s = '0; f_v = '0; f_i = '0; f_s = '0;
        end else begin
            if (fsync) begin
                m_act = 1; m_pos = 0; m_grp = grp_sel;
                f_v = h_v; f_i = h_i; f_s = h_s;
            end else if (m_act) begin
                m_pos++;
                if (m_pos == 512) begin m_act = 0; m_pos = 0; end
            end
            if (volt_vld) h_v = volt_data;
            if (curr_vld) h_i = curr_data;
            if (sup_vld)  h_s = sup_data;
        end
        fsync = 1'b0; volt_vld = 1'b0; curr_vld = 1'b0; sup_vld = 1'b0;
    endtask

    task automatic load(input logic [15:0] v, input logic [15:0] c, input logic [7:0] s);
        volt_data = v; curr_data = c; sup_data = s;
        volt_vld = 1'b1; curr_vld = 1'b1; sup_vld = 1'b1;
    endtask

    task automatic frame(input int g, input int nslots, input string req);
        grp_sel = 2'(g);
        fsync = 1'b1;
        for (int i = 0; i < nslots * 16; i++) tick(req);
    endtask

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) tick("R1");
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) tick("R1");

        load(16'hA5C3, 16'h3C5A, 8'h96);
        tick("R6");
        // R2: MSB-first timing against the sync edge
        frame(0, 4, "R2");
        frame(0, 4, "R2");

        // R3 / R7: sweep every group over every frame length
        for (int g = 0; g < 4; g++) begin
            for (int n = 4; n <= 16; n += 4) begin
                load(16'h1234 ^ 16'((g * 16 + n) * 16'h0F1D),
                     16'hFEDC - 16'((g + 1) * n * 16'h0101),
                     8'((g * 37 + n * 11) ^ 8'h5A));
                tick("R3");
                frame(g, n, "R3");
                frame(g, n, "R7");
            end
        end

        // R6: strobe in mid-frame, then strobe on the sync edge
        grp_sel = 2'd0;
        fsync = 1'b1;
        for (int i = 0; i < 64; i++) begin
            if (i == 20) load(16'h8001, 16'h7FFE, 8'h81);
            tick("R6");
        end
        frame(0, 4, "R6");
        load(16'h0F0F, 16'hF0F0, 8'hC3);
        frame(0, 4, "R6");
        frame(0, 4, "R6");

        // R8 coasting, R9 loss of sync, then recovery
        grp_sel = 2'd1;
        fsync = 1'b1;
        for (int i = 0; i < 640; i++) tick(i < 512 ? "R8" : "R9");
        frame(1, 8, "R9");
        frame(1, 8, "R9");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        bad++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule